// File: doc/BRIEF.md
# Video Beam Position Counter Readout

This block forms the 16-bit beam position value that a host processor sees when it reads the counter location of the video port window. The upper byte is a vertical count: the current scanline less the first visible scanline, advanced by one once the line's horizontal interrupt has gone by, and kept to eight bits. The lower byte is the horizontal position. When the video mode register selects an interlaced mode, the lowest bit of the vertical byte is cleared.

Scanline, first visible line, event phase, horizontal position and the mode register all come from the video timing logic as inputs. The block decodes each bus request against the port window. It answers legal reads of the counter one cycle after the request with a valid pulse. Illegal accesses at the counter location, and the prohibited word slot further up the window, raise an error pulse.

Top module: `hvc_readout`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_valid_o`, `rd_err_o` and `rd_data_o` are all zero.
- R2: A word read (size code 1) at an offset whose word index (`ofs_i[4:1]`) is 4 makes `rd_valid_o` high one cycle later, with `rd_err_o` low, `rd_data_o[15:8]` the vertical byte and `rd_data_o[7:0]` equal to `hpos_i`.
- R3: The vertical byte is (`line_i` − `first_i` + adv) modulo 256, where adv is 0 or 1. It wraps when `line_i` is below `first_i`.
- R4: adv is 1 when `phase_i` is greater than 2, and 0 for phases 0, 1 and 2.
- R5: Interlace is selected when bit 1 or bit 2 of `vmode_i` is set. All other mode bits have no effect on the result.
- R6: In interlace, bit 8 of the word is forced to zero. Every other bit is as in R2.
- R7: A byte read (size code 0) at offset 0x08 returns the vertical byte, and one at offset 0x09 returns the horizontal byte. In both cases the byte is in `rd_data_o[7:0]` and the upper bits are zero.
- R8: A write of byte, word or long size (codes 0, 1, 2) at word index 4 gives `rd_err_o` high for one cycle, with `rd_valid_o` low and data zero.
- R9: A long read (size code 2) at word index 4 gives `rd_valid_o` and `rd_err_o` both high, with data zero.
- R10: A word read at word index 8 (offsets 0x10 and 0x11) gives `rd_valid_o` and `rd_err_o` high, with data zero.
- R11: No request, size code 3, and every other access in the window (any other index, and byte, long or write accesses at index 8) give no valid, no error and zero data.
- R12: Valid and error are single-cycle pulses. Data is zero in every cycle without a valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus request strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| ofs_i | input | 5 | Byte offset inside the video port window |
| line_i | input | 10 | Current scanline |
| first_i | input | 10 | First visible scanline |
| phase_i | input | 3 | Event phase of the current line |
| hpos_i | input | 8 | Horizontal position |
| vmode_i | input | 8 | Video mode register holding the interlace field |
| rd_valid_o | output | 1 | Read result valid pulse |
| rd_err_o | output | 1 | Access error pulse |
| rd_data_o | output | 16 | Read result |

## Verification
The early vertical advance and the interlace bit clearing act on the same bits in the same cycle. Take a raw difference of 0 at phase 3: it becomes 1 and is then cleared back to 0 in interlace. A raw difference of 1 at phase 3 becomes 2 and stays 2. The bench sweeps scanline, first line, all eight phases and several mode values, including masks with only the unrelated bits set. It compares each word against an arithmetic model, so a wrong order of the two operations, or a wrong threshold, shows up as a mismatch in the vertical byte.

// File: rtl/hvc_pkg.sv
package hvc_pkg;

    localparam int HVC_BYTE_W = 8;
    localparam int HVC_WORD_W = 2 * HVC_BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } hvc_size_e;

    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_BYTE_HI = 3'd1,
        ACC_BYTE_LO = 3'd2,
        ACC_WORD    = 3'd3,
        ACC_BAD_RD  = 3'd4,
        ACC_BAD_WR  = 3'd5
    } hvc_acc_e;

    typedef struct packed {
        logic                  valid;
        logic                  err;
        logic [HVC_WORD_W-1:0] data;
    } hvc_out_t;

endpackage

// File: rtl/hvc_line_calc.sv
module hvc_line_calc #(
    parameter int LINE_W    = 10,
    parameter int PH_W      = 3,
    parameter int PH_THRESH = 2
) (
    input  logic [LINE_W-1:0]            line_i,
    input  logic [LINE_W-1:0]            first_i,
    input  logic [PH_W-1:0]              phase_i,
    output logic [hvc_pkg::HVC_BYTE_W-1:0] line8_o
);
    localparam int BW = hvc_pkg::HVC_BYTE_W;

    logic              adv;
    logic [LINE_W-1:0] diff;
    logic              unused_hi;

    always_comb begin
        adv  = (phase_i > PH_W'(PH_THRESH));
        diff = line_i - first_i + LINE_W'(adv);
    end

    assign line8_o = diff[BW-1:0];

    generate
        if (LINE_W > BW) begin : g_hi
            assign unused_hi = ^diff[LINE_W-1:BW];
        end else begin : g_nohi
            assign unused_hi = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/hvc_compose.sv
module hvc_compose #(
    parameter int MODE_W   = 8,
    parameter int ILACE_LO = 1,
    parameter int ILACE_HI = 2
) (
    input  logic [hvc_pkg::HVC_BYTE_W-1:0] line8_i,
    input  logic [hvc_pkg::HVC_BYTE_W-1:0] hpos_i,
    input  logic [MODE_W-1:0]              mode_i,
    output logic [hvc_pkg::HVC_WORD_W-1:0] word_o
);
    localparam int BW = hvc_pkg::HVC_BYTE_W;

    logic [MODE_W-1:0] ilace_mask;
    logic              ilace;
    logic [BW-1:0]     vbyte;

    generate
        for (genvar b = 0; b < MODE_W; b++) begin : g_mask
            assign ilace_mask[b] = (b >= ILACE_LO) && (b <= ILACE_HI);
        end
    endgenerate

    always_comb begin
        ilace = |(mode_i & ilace_mask);
        vbyte = line8_i;
        if (ilace) begin
            vbyte[0] = 1'b0;
        end
        word_o = {vbyte, hpos_i};
    end

endmodule

// File: rtl/hvc_decode.sv
module hvc_decode #(
    parameter int OFS_W      = 5,
    parameter int CNT_IDX    = 4,
    parameter int PROHIB_IDX = 8
) (
    input  logic             req_i,
    input  logic             we_i,
    input  logic [1:0]       size_i,
    input  logic [OFS_W-1:0] ofs_i,
    output hvc_pkg::hvc_acc_e kind_o
);
    import hvc_pkg::*;

    localparam int IDX_W = OFS_W - 1;

    logic [IDX_W-1:0] idx;
    hvc_size_e        sz;

    always_comb begin
        idx    = ofs_i[OFS_W-1:1];
        sz     = hvc_size_e'(size_i);
        kind_o = ACC_NONE;
        if (req_i) begin
            if (idx == IDX_W'(CNT_IDX)) begin
                if (we_i) begin
                    if (sz != SZ_RSVD) begin
                        kind_o = ACC_BAD_WR;
                    end
                end else begin
                    case (sz)
                        SZ_BYTE: kind_o = ofs_i[0] ? ACC_BYTE_LO : ACC_BYTE_HI;
                        SZ_WORD: kind_o = ACC_WORD;
                        SZ_LONG: kind_o = ACC_BAD_RD;
                        default: kind_o = ACC_NONE;
                    endcase
                end
            end else if (idx == IDX_W'(PROHIB_IDX) && !we_i && sz == SZ_WORD) begin
                kind_o = ACC_BAD_RD;
            end
        end
    end

endmodule

// File: rtl/hvc_readout.sv
module hvc_readout #(
    parameter int LINE_W     = 10,
    parameter int PH_W       = 3,
    parameter int PH_THRESH  = 2,
    parameter int MODE_W     = 8,
    parameter int ILACE_LO   = 1,
    parameter int ILACE_HI   = 2,
    parameter int OFS_W      = 5,
    parameter int CNT_IDX    = 4,
    parameter int PROHIB_IDX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        size_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] first_i,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [7:0]        hpos_i,
    input  logic [MODE_W-1:0] vmode_i,
    output logic              rd_valid_o,
    output logic              rd_err_o,
    output logic [15:0]       rd_data_o
);
    import hvc_pkg::*;

    localparam int BW = HVC_BYTE_W;

    logic [BW-1:0]         line8;
    logic [HVC_WORD_W-1:0] word;
    hvc_acc_e              kind;
    hvc_out_t              out_d, out_q;

    hvc_line_calc #(
        .LINE_W   (LINE_W),
        .PH_W     (PH_W),
        .PH_THRESH(PH_THRESH)
    ) u_line (
        .line_i (line_i),
        .first_i(first_i),
        .phase_i(phase_i),
        .line8_o(line8)
    );

    hvc_compose #(
        .MODE_W  (MODE_W),
        .ILACE_LO(ILACE_LO),
        .ILACE_HI(ILACE_HI)
    ) u_comp (
        .line8_i(line8),
        .hpos_i (hpos_i),
        .mode_i (vmode_i),
        .word_o (word)
    );

    hvc_decode #(
        .OFS_W     (OFS_W),
        .CNT_IDX   (CNT_IDX),
        .PROHIB_IDX(PROHIB_IDX)
    ) u_dec (
        .req_i (req_i),
        .we_i  (we_i),
        .size_i(size_i),
        .ofs_i (ofs_i),
        .kind_o(kind)
    );

    always_comb begin
        out_d = '0;
        case (kind)
            ACC_BYTE_HI: begin
                out_d.valid = 1'b1;
                out_d.data  = {{BW{1'b0}}, word[HVC_WORD_W-1:BW]};
            end
            ACC_BYTE_LO: begin
                out_d.valid = 1'b1;
                out_d.data  = {{BW{1'b0}}, word[BW-1:0]};
            end
            ACC_WORD: begin
                out_d.valid = 1'b1;
                out_d.data  = word;
            end
            ACC_BAD_RD: begin
                out_d.valid = 1'b1;
                out_d.err   = 1'b1;
            end
            ACC_BAD_WR: begin
                out_d.err = 1'b1;
            end
            default: out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_valid_o = out_q.valid;
    assign rd_err_o   = out_q.err;
    assign rd_data_o  = out_q.data;

endmodule

// File: rtl/hvc_readout_chk.sv
module hvc_readout_chk #(
    parameter int MODE_W     = 8,
    parameter int ILACE_LO   = 1,
    parameter int ILACE_HI   = 2,
    parameter int OFS_W      = 5,
    parameter int CNT_IDX    = 4,
    parameter int PROHIB_IDX = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              we_i,
    input logic [1:0]        size_i,
    input logic [OFS_W-1:0]  ofs_i,
    input logic [7:0]        hpos_i,
    input logic [MODE_W-1:0] vmode_i,
    input logic              rd_valid_o,
    input logic              rd_err_o,
    input logic [15:0]       rd_data_o
);
    localparam int IDX_W = OFS_W - 1;

    logic cnt_word_rd;
    logic prohib_rd;
    logic ilace_sel;

    always_comb begin
        cnt_word_rd = req_i && !we_i && size_i == 2'd1
                      && ofs_i[OFS_W-1:1] == IDX_W'(CNT_IDX);
        prohib_rd   = req_i && !we_i && size_i == 2'd1
                      && ofs_i[OFS_W-1:1] == IDX_W'(PROHIB_IDX);
        ilace_sel   = |vmode_i[ILACE_HI:ILACE_LO];
    end

    AST_WORD_HPOS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_word_rd |=> rd_valid_o && !rd_err_o && rd_data_o[7:0] == $past(hpos_i)); // R2

    AST_ILACE_BIT8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_word_rd && ilace_sel) |=> rd_data_o[8] == 1'b0); // R6

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i) |=> !rd_valid_o && rd_data_o == '0); // R8

    AST_PROHIB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        prohib_rd |=> rd_valid_o && rd_err_o && rd_data_o == '0); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !rd_valid_o && !rd_err_o); // R11

    AST_DATA_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> rd_data_o == '0); // R12

endmodule

bind hvc_readout hvc_readout_chk #(
    .MODE_W    (MODE_W),
    .ILACE_LO  (ILACE_LO),
    .ILACE_HI  (ILACE_HI),
    .OFS_W     (OFS_W),
    .CNT_IDX   (CNT_IDX),
    .PROHIB_IDX(PROHIB_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .we_i      (we_i),
    .size_i    (size_i),
    .ofs_i     (ofs_i),
    .hpos_i    (hpos_i),
    .vmode_i   (vmode_i),
    .rd_valid_o(rd_valid_o),
    .rd_err_o  (rd_err_o),
    .rd_data_o (rd_data_o)
);

// File: tb/hvc_readout_tb.sv
`timescale 1ns/1ps
module hvc_readout_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [4:0]  ofs_i = 5'd0;
    logic [9:0]  line_i = 10'd0;
    logic [9:0]  first_i = 10'd0;
    logic [2:0]  phase_i = 3'd0;
    logic [7:0]  hpos_i = 8'd0;
    logic [7:0]  vmode_i = 8'd0;
    logic        rd_valid_o;
    logic        rd_err_o;
    logic [15:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hvc_readout u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .size_i(size_i), .ofs_i(ofs_i), .line_i(line_i), .first_i(first_i),
        .phase_i(phase_i), .hpos_i(hpos_i), .vmode_i(vmode_i),
        .rd_valid_o(rd_valid_o), .rd_err_o(rd_err_o), .rd_data_o(rd_data_o)
    );

    function automatic logic [15:0] ref_word(int ln, int fl, int ph, int hp, int md);
        int v;
        v = (ln - fl + ((ph > 2) ? 1 : 0)) & 255;
        if ((md & 6) != 0) v = v & 8'hFE;
        return 16'((v << 8) | (hp & 255));
    endfunction

    task automatic check(string req, logic v, logic e, logic [15:0] d);
        checks++;
        if (rd_valid_o !== v || rd_err_o !== e || rd_data_o !== d) begin
            errors++;
            $display("FAIL %s: got valid=%0b err=%0b data=%h, expected valid=%0b err=%0b data=%h",
                     req, rd_valid_o, rd_err_o, rd_data_o, v, e, d);
        end
    endtask

    task automatic access(logic w, logic [1:0] sz, logic [4:0] o);
        @(negedge clk);
        req_i = 1'b1; we_i = w; size_i = sz; ofs_i = o;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: got cycles=%0d, expected end before 150000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 1'b0, 16'h0);

        // R2 R3 R4 R5 R6: word sweep
        for (int ln = 0; ln < 1024; ln += 37) begin
            for (int fi = 0; fi < 4; fi++) begin
                for (int ph = 0; ph < 8; ph++) begin
                    for (int mi = 0; mi < 6; mi++) begin
                        int md;
                        int fl;
                        md = (mi == 0) ? 0 : (mi == 1) ? 2 : (mi == 2) ? 4 :
                             (mi == 3) ? 6 : (mi == 4) ? 8'hF9 : 8'h03;
                        fl = (fi == 0) ? 0 : (fi == 1) ? 5 : (fi == 2) ? 128 : 300;
                        line_i = 10'(ln); first_i = 10'(fl); phase_i = 3'(ph);
                        vmode_i = 8'(md); hpos_i = 8'((ln * 7 + ph * 29 + mi) & 255);
                        access(1'b0, 2'd1, 5'h08);
                        check("R2_R3_R4_R5_R6", 1'b1, 1'b0,
                              ref_word(ln, fl, ph, int'(hpos_i), md));
                    end
                end
            end
        end

        // R4 R6: advance and interlace on the same bits
        line_i = 10'd40; first_i = 10'd40; hpos_i = 8'h77; vmode_i = 8'h02;
        phase_i = 3'd3;
        access(1'b0, 2'd1, 5'h08);
        check("R4_R6 clear after advance", 1'b1, 1'b0, 16'h0077);
        line_i = 10'd41;
        access(1'b0, 2'd1, 5'h08);
        check("R4_R6 advance to 2", 1'b1, 1'b0, 16'h0277);
        phase_i = 3'd2; vmode_i = 8'h00;
        access(1'b0, 2'd1, 5'h08);
        check("R4 phase 2 no advance", 1'b1, 1'b0, 16'h0177);
        line_i = 10'd2; first_i = 10'd5;
        access(1'b0, 2'd1, 5'h09);
        check("R3 wrap, R2 odd word offset", 1'b1, 1'b0, 16'hFD77);

        // R7: byte reads
        for (int ph = 0; ph < 8; ph++) begin
            line_i = 10'd200; first_i = 10'd17; phase_i = 3'(ph); hpos_i = 8'hA5;
            vmode_i = (ph[0]) ? 8'h04 : 8'h00;
            access(1'b0, 2'd0, 5'h08);
            check("R7 even byte", 1'b1, 1'b0, {8'h00, ref_word(200, 17, ph, 8'hA5, int'(vmode_i))[15:8]});
            access(1'b0, 2'd0, 5'h09);
            check("R7 odd byte", 1'b1, 1'b0, 16'h00A5);
        end

        // R8: writes at the counter
        for (int sz = 0; sz < 3; sz++) begin
            for (int o = 8; o < 10; o++) begin
                access(1'b1, 2'(sz), 5'(o));
                check("R8 write error", 1'b0, 1'b1, 16'h0);
            end
        end

        // R9: long read
        access(1'b0, 2'd2, 5'h08);
        check("R9 long read", 1'b1, 1'b1, 16'h0);

        // R10: prohibited word slot
        access(1'b0, 2'd1, 5'h10);
        check("R10 prohibited", 1'b1, 1'b1, 16'h0);
        access(1'b0, 2'd1, 5'h11);
        check("R10 prohibited odd", 1'b1, 1'b1, 16'h0);

        // R11: ignored accesses
        access(1'b0, 2'd3, 5'h08);
        check("R11 reserved size", 1'b0, 1'b0, 16'h0);
        access(1'b1, 2'd3, 5'h08);
        check("R11 reserved size write", 1'b0, 1'b0, 16'h0);
        access(1'b0, 2'd0, 5'h10);
        check("R11 byte at prohibited", 1'b0, 1'b0, 16'h0);
        access(1'b0, 2'd2, 5'h10);
        check("R11 long at prohibited", 1'b0, 1'b0, 16'h0);
        access(1'b1, 2'd1, 5'h10);
        check("R11 write at prohibited", 1'b0, 1'b0, 16'h0);
        for (int o = 0; o < 32; o++) begin
            if ((o >> 1) != 4 && (o >> 1) != 8) begin
                access(1'b0, 2'd1, 5'(o));
                check("R11 other offset", 1'b0, 1'b0, 16'h0);
            end
        end

        // R12: pulses last one cycle
        access(1'b0, 2'd1, 5'h08);
        @(negedge clk);
        check("R12 valid pulse ends", 1'b0, 1'b0, 16'h0);
        access(1'b1, 2'd0, 5'h08);
        @(negedge clk);
        check("R12 error pulse ends", 1'b0, 1'b0, 16'h0);

        finish_run();
    end

endmodule